// File: doc/BRIEF.md
# SPI EEPROM Byte Write Sequencer

This block stores a single byte into a serial EEPROM that takes a 16-bit address, and it does so without software involvement. The caller places an address and a data byte on the inputs and pulses `start`. The block then drives the SPI pins. It reads the device status repeatedly until the device reports that no internal write is in progress. It sends a write-enable command in a frame of its own. It then sends the write command, the address and the byte in one chip-select frame. At the end it pulses either `done` or `timeout`.

Every SPI bit has the same shape. The output bit is placed on MOSI while SCK is low, and SCK then goes high for one half-period and low again. MISO is captured at the end of the low half, just before SCK rises. The half-period length is set in system clocks by `DIV`. The poll limit is set in system clocks by `TIMEOUT_CYC`, and its default is ten seconds of a 250 MHz clock. A status read that still shows the device busy after that limit ends the operation with `timeout`, and no write-enable or write frame is sent.

Top module: `spi_byte_writer`

## Requirements
- R1: After reset, and whenever `busy` is low, `spi_cs_n` is 1, `spi_sck` is 0, and `done` and `timeout` are 0.
- R2: Each status poll is one chip-select-low frame of 16 SCK pulses. The first 8 MOSI bits are the byte 0x05, sent MSB first. The last 8 pulses read status bits from MISO, MSB first.
- R3: The block reads only status bit 0, which is the last bit captured in a poll. When it is 1 the poll is repeated. When it is 0 the block moves on to write-enable. The other seven status bits have no effect.
- R4: A poll whose bit 0 reads 1 after at least `TIMEOUT_CYC` clocks have passed since `start` ends the operation with a `timeout` pulse. In that case no write-enable frame, no write frame and no extra SCK pulse is issued.
- R5: Write-enable is a separate frame of 8 pulses carrying 0x06 MSB first. After CS rises it is followed by exactly one SCK pulse with CS held high.
- R6: The write frame is one chip-select-low frame of 32 pulses. It carries 0x02, then `addr[15:0]`, then `data[7:0]`, each MSB first.
- R7: SCK is low when idle. MOSI changes only while SCK is low and is stable for the whole SCK-high half.
- R8: Between consecutive frames of one operation, CS stays high for at least `DIV` clocks.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until the operation ends. It falls in the same cycle as a one-cycle `done` or `timeout` pulse, and those two pulses never occur together.
- R10: A `start` that arrives while `busy` is high is ignored. The write that is in progress uses the address and data captured at the accepted `start`, and no second operation follows.
- R11: Every SCK-high half lasts exactly `DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a byte write; taken only while idle |
| addr | input | 16 | EEPROM byte address, captured at start |
| data | input | 8 | Byte to store, captured at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the write frame has finished |
| timeout | output | 1 | One-cycle pulse when status polling has given up |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |

## Verification
The hardest case to reach from the ports is the timeout, and the poll loop that precedes it. It needs a device that keeps reporting busy across dozens of complete status frames. The bench provides this with a behavioural SPI device model whose count of busy replies can be set per test. The bench shortens `TIMEOUT_CYC`, lets the model reply busy indefinitely, and checks the length of the timeout window. It also checks that no write-enable frame, write frame or extra clock pulse ever appears. Ready replies with the upper status bits set show that only bit 0 is decoded. A second `start` carrying different operands, issued in the middle of the polling, covers the ignore rule.

// File: rtl/spi_byte_writer.sv
module spi_byte_writer #(
  parameter int DIV = 4,
  parameter int unsigned TIMEOUT_CYC = 32'd2_500_000_000,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CMD_W   = 8;
  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
  localparam int BC_W    = $clog2(FRAME_W);
  localparam int DW      = $clog2(DIV) + 1;
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CMD_W-1:0] OP_STAT = 8'h05;
  localparam logic [CMD_W-1:0] OP_WEN  = 8'h06;
  localparam logic [CMD_W-1:0] OP_WR   = 8'h02;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_CSUP, S_XHI, S_XLO} st_t;
  typedef enum logic [1:0] {F_POLL, F_WEN, F_WR} fr_t;

  st_t               st;
  fr_t               fr;
  logic [DW-1:0]     div_cnt;
  logic [TW-1:0]     tmo_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [BC_W-1:0]   last_bit;
  logic [FRAME_W-1:0] tx;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              sck_q;
  logic              miso_q;
  logic              tick;

  assign busy     = (st != S_IDLE);
  assign spi_cs_n = (st != S_SHIFT);
  assign spi_mosi = tx[FRAME_W-1];
  assign spi_sck  = sck_q;
  assign tick     = busy && (div_cnt == DW'(DIV - 1));

  always_comb begin
    case (fr)
      F_POLL:  last_bit = BC_W'(2 * CMD_W - 1);
      F_WEN:   last_bit = BC_W'(CMD_W - 1);
      default: last_bit = BC_W'(FRAME_W - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fr      <= F_POLL;
      div_cnt <= '0;
      tmo_cnt <= '0;
      bit_cnt <= '0;
      tx      <= '0;
      a_q     <= '0;
      d_q     <= '0;
      sck_q   <= 1'b0;
      miso_q  <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (busy) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;
      end
      case (st)
        S_IDLE: begin
          div_cnt <= '0;
          sck_q   <= 1'b0;
          if (start) begin
            a_q     <= addr;
            d_q     <= data;
            tmo_cnt <= '0;
            fr      <= F_POLL;
            tx      <= {OP_STAT, {(FRAME_W-CMD_W){1'b0}}};
            bit_cnt <= '0;
            st      <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick) begin
          if (!sck_q) begin
            miso_q <= spi_miso;
            sck_q  <= 1'b1;
          end else begin
            sck_q   <= 1'b0;
            tx      <= tx << 1;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == last_bit) st <= S_CSUP;
          end
        end
        S_CSUP: if (tick) begin
          case (fr)
            F_POLL: begin
              bit_cnt <= '0;
              if (!miso_q) begin
                fr <= F_WEN;
                tx <= {OP_WEN, {(FRAME_W-CMD_W){1'b0}}};
                st <= S_SHIFT;
              end else if (tmo_cnt >= TW'(TIMEOUT_CYC)) begin
                timeout <= 1'b1;
                st      <= S_IDLE;
              end else begin
                tx <= {OP_STAT, {(FRAME_W-CMD_W){1'b0}}};
                st <= S_SHIFT;
              end
            end
            F_WEN: begin
              sck_q <= 1'b1;
              st    <= S_XHI;
            end
            default: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end
        S_XHI: if (tick) begin
          sck_q <= 1'b0;
          st    <= S_XLO;
        end
        S_XLO: if (tick) begin
          fr      <= F_WR;
          tx      <= {OP_WR, a_q, d_q};
          bit_cnt <= '0;
          st      <= S_SHIFT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_writer_chk.sv
module spi_byte_writer_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic sck,
  input logic cs_n,
  input logic mosi
);
  logic [15:0] hi_cnt;
  logic [15:0] cs_hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      cs_hi_cnt <= '0;
    end else begin
      hi_cnt    <= sck  ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
      cs_hi_cnt <= cs_n ? ((cs_hi_cnt == '1) ? cs_hi_cnt : cs_hi_cnt + 1'b1) : '0;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_sck_high_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_cnt == 16'(DIV)));
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && $past(busy)) |-> (cs_hi_cnt >= 16'(DIV)));
  p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout));
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind spi_byte_writer spi_byte_writer_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timeout(timeout), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
);

// File: tb/tb_spi_byte_writer.sv
module tb_spi_byte_writer;
  localparam int DIV = 2;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic busy, done, timeout, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_byte_writer #(.DIV(DIV), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .data(data),
    .busy(busy), .done(done), .timeout(timeout), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0;
  int errors = 0;

  // device model
  int nb;
  logic [31:0] sr;
  logic [7:0] cmd;
  int busy_left;
  logic [7:0] st_busy, st_ready;
  int fcnt;
  int xpulses;
  int log_nb [64];
  logic [31:0] log_sr [64];

  always @(negedge spi_cs_n) begin
    nb = 0; sr = '0; cmd = '0; spi_miso = 1'b0;
  end
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      sr = {sr[30:0], spi_mosi};
      nb++;
      if (nb == 8) cmd = sr[7:0];
    end else xpulses++;
  end
  always @(negedge spi_sck) begin
    if (!spi_cs_n && cmd == 8'h05 && nb >= 8 && nb < 16)
      spi_miso = (busy_left > 0) ? st_busy[15-nb] : st_ready[15-nb];
  end
  always @(posedge spi_cs_n) begin
    if (fcnt < 64) begin
      log_nb[fcnt] = nb;
      log_sr[fcnt] = sr;
    end
    fcnt++;
    if (cmd == 8'h05 && busy_left > 0) busy_left--;
  end

  // line monitors
  int hirun = 0, himin = 9999, himax = 0;
  int gap = 0, gmin = 9999;
  int mosi_bad = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck) hirun++;
      else if (hirun > 0) begin
        if (hirun < himin) himin = hirun;
        if (hirun > himax) himax = hirun;
        hirun = 0;
      end
      if (busy && spi_cs_n) gap++;
      else if (!spi_cs_n) begin
        if (gap > 0 && gap < gmin) gmin = gap;
        gap = 0;
      end else gap = 0;
      if (spi_sck && p_sck && spi_mosi !== p_mosi) mosi_bad++;
      p_sck = spi_sck;
      p_mosi = spi_mosi;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    fcnt = 0; xpulses = 0;
  endtask

  task automatic run_op(input logic [15:0] a, input logic [7:0] d, input int nbusy,
                        input logic [7:0] sb, input logic [7:0] sr_ok, input int restart_at,
                        output bit dn, output bit to, output int cyc, output int drop);
    busy_left = nbusy; st_busy = sb; st_ready = sr_ok;
    clear_log();
    dn = 0; to = 0; cyc = 0; drop = 0;
    @(negedge clk);
    addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 20000) begin
      cyc++;
      if (restart_at != 0 && cyc == restart_at) begin
        addr = ~a; data = ~d; start = 1'b1;
      end else start = 1'b0;
      if (done) begin dn = 1; break; end
      if (timeout) begin to = 1; break; end
      if (!busy) drop++;
      @(negedge clk);
    end
    if (timeout) to = 1;
  endtask

  localparam bit [47:0] VECS [0:5] = '{
    {16'h0000, 8'h00, 8'd0, 8'h01, 8'h00},
    {16'hFFFF, 8'hFF, 8'd1, 8'h01, 8'h00},
    {16'hA55A, 8'h3C, 8'd2, 8'hFF, 8'hFE},
    {16'h8001, 8'h80, 8'd3, 8'h81, 8'h7E},
    {16'h1234, 8'h01, 8'd0, 8'h01, 8'hFE},
    {16'h7FFE, 8'hC3, 8'd1, 8'h03, 8'h02}
  };

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit dn, to;
    int cyc, drop;
    busy_left = 0; st_busy = 8'h01; st_ready = 8'h00;
    fcnt = 0; xpulses = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0 && timeout == 1'b0, "R1", "done/timeout after reset", {done, timeout}, 0);

    foreach (VECS[i]) begin
      logic [15:0] va; logic [7:0] vd; int vn;
      va = VECS[i][47:32]; vd = VECS[i][31:24]; vn = int'(VECS[i][23:16]);
      run_op(va, vd, vn, VECS[i][15:8], VECS[i][7:0], 0, dn, to, cyc, drop);
      @(negedge clk);
      chk(dn && !to && drop == 0 && !busy, "R9", "done pulse and busy window", {dn, to, 6'(drop)}, 8'h80);
      chk(fcnt == vn + 3, "R3", "frame count", fcnt, vn + 3);
      for (int k = 0; k <= vn && k < 64; k++)
        chk(log_nb[k] == 16 && log_sr[k][15:8] == 8'h05, "R2", "poll frame",
            {log_nb[k], log_sr[k][15:0]}, {16, 16'h0500});
      if (fcnt == vn + 3) begin
        chk(log_nb[vn+1] == 8 && log_sr[vn+1][7:0] == 8'h06, "R5", "write-enable frame",
            {log_nb[vn+1], log_sr[vn+1][7:0]}, {8, 8'h06});
        chk(log_nb[vn+2] == 32 && log_sr[vn+2] == {8'h02, va, vd}, "R6", "write frame",
            log_sr[vn+2], {8'h02, va, vd});
      end
      chk(xpulses == 1, "R5", "extra clock after write-enable", xpulses, 1);
    end

    // R10: second start mid-operation with different operands
    run_op(16'hC0DE, 8'h5A, 2, 8'h01, 8'h00, 40, dn, to, cyc, drop);
    start = 1'b0;
    chk(dn && !to, "R10", "operation completes", {dn, to}, 2'b10);
    chk(fcnt == 5 && log_sr[4] == {8'h02, 16'hC0DE, 8'h5A}, "R10", "write uses captured operands",
        log_sr[4], {8'h02, 16'hC0DE, 8'h5A});
    repeat (300) @(negedge clk);
    chk(fcnt == 5 && !busy, "R10", "no second operation", fcnt, 5);

    // R4: device never ready
    run_op(16'h4444, 8'h44, 100000, 8'h01, 8'h00, 0, dn, to, cyc, drop);
    chk(to && !dn, "R4", "timeout pulse", {to, dn}, 2'b10);
    chk(cyc >= TMO && cyc <= TMO + 34 * DIV + 4, "R4", "timeout window", cyc, TMO);
    begin
      int bad = 0;
      for (int k = 0; k < fcnt && k < 64; k++)
        if (log_nb[k] != 16 || log_sr[k][15:8] != 8'h05) bad++;
      chk(bad == 0 && xpulses == 0, "R4", "only poll frames before timeout", bad + xpulses, 0);
    end
    repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n && !spi_sck, "R1", "idle after timeout", {busy, spi_cs_n, spi_sck}, 3'b010);

    // line-level monitors
    chk(mosi_bad == 0, "R7", "MOSI stable while SCK high", mosi_bad, 0);
    chk(himin == DIV && himax == DIV, "R11", "SCK high length", {himin, himax}, {DIV, DIV});
    chk(gmin >= DIV, "R8", "CS high gap between frames", gmin, DIV);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule